// File: doc/BRIEF.md
# Memory-write MSI vector decoder

This block sits on the inbound message path of a root-port bridge. Every cycle it may receive one memory-write message made of a 64-bit address and a 32-bit data word. When the bridge is enabled and the address equals a 64-bit target programmed by software, the data word is taken as a vector number. It sets one pending bit among 64 vectors. The vectors are held in two 32-bit banks. Each bank has a pending-status register, an enable register and its own interrupt line.

Software uses a 32-bit register port. Through it, software programs the target address, turns the bridge on, enables vectors, and reads pending bits or clears them by writing ones. Register reads are combinational from the current state. A write or a message updates state at the clock edge where it is presented, and the change is visible from the next cycle.

Top module: `msi_vec_decoder`

## Requirements
- R1: After reset every register reads 0 and both interrupt lines are low.
- R2: The upper half of the target address is written and read at offset 0x14C and the lower half at offset 0x150. Only bit 0 of the control register at offset 0x148 is stored; its other bits read 0.
- R3: A message that matches, with data value v in the range 0 to 31, sets bit v of the low-bank status at offset 0x170.
- R4: A message that matches, with data value v in the range 32 to 63, sets bit v-32 of the high-bank status at offset 0x174 and leaves the low bank unchanged.
- R5: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.
- R6: The enable registers are at offset 0x178 (low bank) and 0x17C (high bank), where 1 means enabled. irq_o[0] is high exactly when low status AND low enable is non-zero. irq_o[1] follows the same rule for the high bank.
- R7: A vector whose enable bit is 0 still latches its status bit, and setting its enable bit later raises the bank line.
- R8: A message is ignored and sets no status bit when its data value is 64 or more, or when either address half differs from the target.
- R9: While control bit 0 (bridge enable) is 0, every message is ignored.
- R10: When a message and a clearing write hit the same status bit in the same cycle, the bit stays set. Other bits in that write still clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Inbound memory-write message present |
| msg_addr_i | input | 64 | Message target address |
| msg_data_i | input | 32 | Message data word (vector number) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 2 | Bank interrupt lines, bit 0 low bank, bit 1 high bank |

## Verification
Messages are sent with vector numbers from both banks, including the top vector 63. Each time, the status of the other bank is read to confirm that a vector lands in exactly one bank at the right bit. Data value 64 and addresses that differ only in the lower half or only in the upper half separate the range check from the full 64-bit compare. A message sent with the bridge off shows that the enable gate works on its own. A vector that is latched while disabled and then enabled shows that status and enable are kept apart. A clearing write that carries both a racing bit and an unrelated bit shows that a new message wins only on its own bit.

// File: rtl/msi_dec_pkg.sv
package msi_dec_pkg;
  localparam int unsigned NUM_VEC  = 64;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned OFF_W    = 12;
  localparam int unsigned MADDR_W  = 64;

  localparam logic [OFF_W-1:0] OFF_CTRL    = 12'h148;
  localparam logic [OFF_W-1:0] OFF_BASE_HI = 12'h14C;
  localparam logic [OFF_W-1:0] OFF_BASE_LO = 12'h150;
  localparam logic [OFF_W-1:0] OFF_STAT0   = 12'h170;

  typedef struct packed {
    logic               en;
    logic [MADDR_W-1:0] base;
  } msi_cfg_t;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_dec_pkg::*;
#(
  parameter int unsigned RW = REG_W,
  parameter int unsigned AW = OFF_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [RW-1:0] wdata_i,
  output msi_cfg_t      cfg_o
);
  logic          en_q;
  logic [RW-1:0] hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      hi_q <= '0;
      lo_q <= '0;
    end else if (we_i) begin
      if (addr_i == OFF_CTRL)    en_q <= wdata_i[0];
      if (addr_i == OFF_BASE_HI) hi_q <= wdata_i;
      if (addr_i == OFF_BASE_LO) lo_q <= wdata_i;
    end
  end

  assign cfg_o.en   = en_q;
  assign cfg_o.base = {hi_q, lo_q};

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == OFF_CTRL) |=> $stable(cfg_o.en)); // R9
endmodule

// File: rtl/msi_match.sv
module msi_match
  import msi_dec_pkg::*;
#(
  parameter int unsigned NV = NUM_VEC,
  parameter int unsigned AW = MADDR_W,
  parameter int unsigned DW = REG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  msi_cfg_t      cfg_i,
  output logic [NV-1:0] set_o
);
  localparam int unsigned IDX_W = $clog2(NV);
  localparam logic [DW-1:0] LIMIT = DW'(NV);

  logic            hit;
  logic [IDX_W-1:0] idx;

  assign idx = data_i[IDX_W-1:0];
  assign hit = valid_i && cfg_i.en && (addr_i == cfg_i.base) && (data_i < LIMIT);

  always_comb begin
    set_o = '0;
    if (hit) set_o[idx] = 1'b1;
  end

  AST_ONE_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(set_o)); // R3
  AST_DATA_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_i >= LIMIT) |-> (set_o == '0)); // R8
  AST_ADDR_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != cfg_i.base) |-> (set_o == '0)); // R8
  AST_BRIDGE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |-> (set_o == '0)); // R9
endmodule

// File: rtl/msi_bank.sv
module msi_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] stat_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      // new arrival beats a same-cycle clear
      stat_q <= (stat_q & ~clr_i) | set_i;
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & mask_q);

  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i))); // R10
  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((stat_q & $past(clr_i & ~set_i)) == '0)); // R5
  AST_STAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(stat_q)); // R3
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o); // R6
endmodule

// File: rtl/msi_vec_decoder.sv
module msi_vec_decoder
  import msi_dec_pkg::*;
#(
  parameter int unsigned NV = NUM_VEC,
  parameter int unsigned RW = REG_W,
  parameter int unsigned AW = OFF_W,
  parameter int unsigned MW = MADDR_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 msg_valid_i,
  input  logic [MW-1:0]        msg_addr_i,
  input  logic [RW-1:0]        msg_data_i,
  input  logic                 reg_we_i,
  input  logic [AW-1:0]        reg_addr_i,
  input  logic [RW-1:0]        reg_wdata_i,
  output logic [RW-1:0]        reg_rdata_o,
  output logic [NV/RW-1:0]     irq_o
);
  localparam int unsigned NB = NV / RW;
  localparam logic [AW-1:0] OFF_MASK0 = OFF_STAT0 + AW'(4 * NB);

  msi_cfg_t      cfg;
  logic [NV-1:0] set_vec;
  logic [RW-1:0] stat [NB];
  logic [RW-1:0] mask [NB];

  msi_cfg_regs #(.RW(RW), .AW(AW)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .cfg_o  (cfg)
  );

  msi_match #(.NV(NV), .AW(MW), .DW(RW)) u_match (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(msg_valid_i),
    .addr_i (msg_addr_i),
    .data_i (msg_data_i),
    .cfg_i  (cfg),
    .set_o  (set_vec)
  );

  for (genvar k = 0; k < NB; k++) begin : g_bank
    localparam logic [AW-1:0] STAT_OFF = OFF_STAT0 + AW'(4 * k);
    localparam logic [AW-1:0] MASK_OFF = OFF_MASK0 + AW'(4 * k);
    logic [RW-1:0] clr;
    assign clr = (reg_we_i && reg_addr_i == STAT_OFF) ? reg_wdata_i : '0;

    msi_bank #(.W(RW)) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .set_i       (set_vec[k*RW +: RW]),
      .clr_i       (clr),
      .mask_we_i   (reg_we_i && reg_addr_i == MASK_OFF),
      .mask_wdata_i(reg_wdata_i),
      .stat_o      (stat[k]),
      .mask_o      (mask[k]),
      .irq_o       (irq_o[k])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFF_CTRL:    reg_rdata_o = {{(RW-1){1'b0}}, cfg.en};
      OFF_BASE_HI: reg_rdata_o = cfg.base[MW-1 -: RW];
      OFF_BASE_LO: reg_rdata_o = cfg.base[RW-1:0];
      default: begin
        for (int k = 0; k < NB; k++) begin
          if (reg_addr_i == OFF_STAT0 + AW'(4 * k)) reg_rdata_o = stat[k];
          if (reg_addr_i == OFF_MASK0 + AW'(4 * k)) reg_rdata_o = mask[k];
        end
      end
    endcase
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (irq_o == '0)); // R1
endmodule

// File: tb/msi_vec_decoder_tb.sv
module msi_vec_decoder_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [63:0] TGT = 64'hDEAD_0001_0000_F000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        msg_valid_i = 1'b0;
  logic [63:0] msg_addr_i = '0;
  logic [31:0] msg_data_i = '0;
  logic        reg_we_i = 1'b0;
  logic [11:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [1:0]  irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  msi_vec_decoder u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .msg_valid_i(msg_valid_i), .msg_addr_i(msg_addr_i), .msg_data_i(msg_data_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic msg(logic [63:0] a, logic [31:0] d);
    @(negedge clk_i);
    msg_valid_i = 1'b1; msg_addr_i = a; msg_data_i = d;
    @(negedge clk_i);
    msg_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    foreach (u_offs[i]) begin
      rd(u_offs[i], v);
      chk("R1 reg", v, 32'h0);
    end
    chk("R1 irq", 32'(irq_o), 32'h0);
  endtask

  logic [11:0] u_offs [7] = '{12'h148, 12'h14C, 12'h150, 12'h170, 12'h174, 12'h178, 12'h17C};

  task automatic t_config;
    logic [31:0] v;
    wr(12'h14C, TGT[63:32]);
    wr(12'h150, TGT[31:0]);
    wr(12'h148, 32'hFFFF_FFFF);
    rd(12'h14C, v); chk("R2 base hi", v, TGT[63:32]);
    rd(12'h150, v); chk("R2 base lo", v, TGT[31:0]);
    rd(12'h148, v); chk("R2 ctrl", v, 32'h1);
  endtask

  task automatic t_low_bank;
    logic [31:0] v;
    wr(12'h178, 32'hFFFF_FFFF);
    rd(12'h178, v); chk("R6 mask lo readback", v, 32'hFFFF_FFFF);
    msg(TGT, 32'd5);
    rd(12'h170, v); chk("R3 status lo", v, 32'h20);
    rd(12'h174, v); chk("R3 status hi untouched", v, 32'h0);
    chk("R6 irq lo only", 32'(irq_o), 32'h1);
    wr(12'h170, 32'h20);
    rd(12'h170, v); chk("R5 cleared", v, 32'h0);
    chk("R5 irq dropped", 32'(irq_o), 32'h0);
  endtask

  task automatic t_high_bank;
    logic [31:0] v;
    wr(12'h17C, 32'h100);
    msg(TGT, 32'd40);
    rd(12'h174, v); chk("R4 status hi", v, 32'h100);
    rd(12'h170, v); chk("R4 status lo untouched", v, 32'h0);
    chk("R6 irq hi only", 32'(irq_o), 32'h2);
    wr(12'h174, 32'h0);
    rd(12'h174, v); chk("R5 zero write keeps", v, 32'h100);
    wr(12'h174, 32'h100);
  endtask

  task automatic t_masked_latch;
    logic [31:0] v;
    wr(12'h17C, 32'h0);
    msg(TGT, 32'd63);
    rd(12'h174, v); chk("R7 latched while disabled", v, 32'h8000_0000);
    chk("R7 no irq while disabled", 32'(irq_o), 32'h0);
    wr(12'h17C, 32'h8000_0000);
    chk("R7 irq on enable", 32'(irq_o), 32'h2);
    wr(12'h174, 32'h8000_0000);
    chk("R7 irq after clear", 32'(irq_o), 32'h0);
  endtask

  task automatic t_ignored;
    logic [31:0] v;
    msg(TGT, 32'd64);
    msg(TGT + 64'd4, 32'd2);
    msg(TGT ^ 64'h0000_0100_0000_0000, 32'd2);
    rd(12'h170, v); chk("R8 status lo", v, 32'h0);
    rd(12'h174, v); chk("R8 status hi", v, 32'h0);
    chk("R8 irq", 32'(irq_o), 32'h0);
  endtask

  task automatic t_bridge_off;
    logic [31:0] v;
    wr(12'h148, 32'h0);
    msg(TGT, 32'd1);
    rd(12'h170, v); chk("R9 off ignores", v, 32'h0);
    wr(12'h148, 32'h1);
    msg(TGT, 32'd1);
    rd(12'h170, v); chk("R9 on accepts", v, 32'h2);
    wr(12'h170, 32'h2);
  endtask

  task automatic t_race;
    logic [31:0] v;
    msg(TGT, 32'd4);
    @(negedge clk_i);
    msg_valid_i = 1'b1; msg_addr_i = TGT; msg_data_i = 32'd3;
    reg_we_i = 1'b1; reg_addr_i = 12'h170; reg_wdata_i = 32'h18;
    @(negedge clk_i);
    msg_valid_i = 1'b0; reg_we_i = 1'b0;
    rd(12'h170, v); chk("R10 set wins, other clears", v, 32'h8);
    wr(12'h170, 32'h8);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    t_reset;
    t_config;
    t_low_bank;
    t_high_bank;
    t_masked_latch;
    t_ignored;
    t_bridge_off;
    t_race;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule